// File: doc/BRIEF.md
# Conditional Multi-State Register-Transfer Sequencer

This block is a small controller with its own datapath. It holds three working registers, A, B and C. After a start pulse it runs a fixed program of register transfers over six control steps, numbered 0 to 5. In each step it makes one or two assignments. The current step and two condition bits, `cond_a` and `cond_c`, choose which assignments are made. The same three things choose the following step. The available operations are addition, bitwise complement and two's-complement negation. All arithmetic wraps at the register width.

The start pulse loads the three initial operands. The sequencer then walks through the branch that the condition bits select, one step per clock. It ends in step 5, where it raises `done` and leaves the registers untouched. The register contents are always visible on the outputs. `done` stays high until the next start pulse or a reset.

Top module: `cond_fsmd`

## Requirements
- R1: A cycle with `start` high loads `a_init`, `b_init` and `c_init` into A, B and C, enters step 0 and clears `done`. The new values are visible after that clock edge.
- R2: In step 0, A takes B + C and the sequencer moves to step 1. No condition bit is consulted.
- R3: In step 1, when `cond_a` is 0, A takes its two's-complement negation (~A + 1) and the next step is 4. When `cond_a` is 1, B takes B + C and the next step is 2.
- R4: In step 2, when `cond_c` is 0, C takes A + B and the next step is 5. When `cond_c` is 1, C takes ~C and the next step is 3.
- R5: In step 3, when `cond_c` is 0, C takes A + B. When `cond_c` is 1, A takes ~C + B. Both branches go to step 5.
- R6: In step 4, when `cond_a` is 0, B takes ~B. If `cond_c` is also 0, A takes A + ~B + C in the same cycle, using the complemented B. When `cond_a` is 1, C takes ~C. Every branch goes to step 5.
- R7: Step 5 is terminal. The registers do not change, the condition bits have no effect and `done` is high. Both hold until the next start pulse.
- R8: Every assignment in a step reads the register values from before the clock edge. All sums and negations wrap modulo 2^W.
- R9: A synchronous active-high `rst` puts the block in idle with A, B and C at zero and `done` low. While idle and without `start`, the registers hold their values whatever the condition bits do.
- R10: A start pulse in the middle of a run abandons that run and restarts from step 0 with the new initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load initial operands and begin at step 0 |
| a_init | input | W | Initial value for A |
| b_init | input | W | Initial value for B |
| c_init | input | W | Initial value for C |
| cond_a | input | 1 | Condition bit tested in steps 1 and 4 |
| cond_c | input | 1 | Condition bit tested in steps 2, 3 and 4 |
| reg_a | output | W | Current contents of A |
| reg_b | output | W | Current contents of B |
| reg_c | output | W | Current contents of C |
| done | output | 1 | High while in the terminal step |

## Verification
The bench drives every combination of condition bits through every step. The path through step 3 is the one most likely to go wrong:
- If the branch decodes are swapped, a run takes the wrong edge in the step graph. Its register values then drift away from the model a cycle or two later.

The step-4 case with both condition bits low is the sharpest probe:
- A design that adds the old B instead of ~B produces the wrong A.
- A design that lets the complemented B affect a different cycle also produces the wrong A.

Operands near all-ones exercise the wrap. A negation that forgets the +1 shows up at once on A.

The bench also covers the terminal and control behaviour:
- It holds step 5 while toggling the condition bits, to catch a terminal step that keeps writing.
- It restarts a run mid-flight, to catch start losing priority to the running program.
- It resets mid-run, to catch stale `done` or stale registers.

// File: rtl/fsmd_pkg.sv
package fsmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S0   = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4,
    ST_S4   = 3'd5,
    ST_S5   = 3'd6
  } fsmd_state_t;

  localparam int NREG  = 3;
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_C = 2;

endpackage

// File: rtl/fsmd_ctrl.sv
module fsmd_ctrl
  import fsmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        cond_a,
  input  logic        cond_c,
  output fsmd_state_t state,
  output logic        done
);

  fsmd_state_t nxt_state;

  always_comb begin
    nxt_state = state;
    if (start) begin
      nxt_state = ST_S0;
    end else begin
      case (state)
        ST_S0:   nxt_state = ST_S1;
        ST_S1:   nxt_state = cond_a ? ST_S2 : ST_S4;
        ST_S2:   nxt_state = cond_c ? ST_S3 : ST_S5;
        ST_S3:   nxt_state = ST_S5;
        ST_S4:   nxt_state = ST_S5;
        ST_S5:   nxt_state = ST_S5;
        default: nxt_state = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt_state;
      done  <= (nxt_state == ST_S5);
    end
  end

  // R1
  start_enter_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (state == ST_S0));

  // R7
  terminal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_S5 && !start) |=> (state == ST_S5));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE));

  // R3
  s1_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_S1 && !start) |=> (state == ($past(cond_a) ? ST_S2 : ST_S4)));

endmodule

// File: rtl/fsmd_alu.sv
module fsmd_alu
  import fsmd_pkg::*;
#(
  parameter int W = 8
) (
  input  fsmd_state_t                 state,
  input  logic                        cond_a,
  input  logic                        cond_c,
  input  logic [NREG-1:0][W-1:0]      cur,
  output logic [NREG-1:0]             we,
  output logic [NREG-1:0][W-1:0]      nxt
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] a_q, b_q, c_q, b_inv;

  assign a_q   = cur[IDX_A];
  assign b_q   = cur[IDX_B];
  assign c_q   = cur[IDX_C];
  assign b_inv = ~b_q;

  always_comb begin
    we  = '0;
    nxt = cur;
    case (state)
      ST_S0: begin
        we[IDX_A]  = 1'b1;
        nxt[IDX_A] = b_q + c_q;
      end
      ST_S1: begin
        if (!cond_a) begin
          we[IDX_A]  = 1'b1;
          nxt[IDX_A] = ~a_q + ONE;
        end else begin
          we[IDX_B]  = 1'b1;
          nxt[IDX_B] = b_q + c_q;
        end
      end
      ST_S2: begin
        we[IDX_C] = 1'b1;
        if (!cond_c) nxt[IDX_C] = a_q + b_q;
        else         nxt[IDX_C] = ~c_q;
      end
      ST_S3: begin
        if (!cond_c) begin
          we[IDX_C]  = 1'b1;
          nxt[IDX_C] = a_q + b_q;
        end else begin
          we[IDX_A]  = 1'b1;
          nxt[IDX_A] = ~c_q + b_q;
        end
      end
      ST_S4: begin
        if (!cond_a) begin
          we[IDX_B]  = 1'b1;
          nxt[IDX_B] = b_inv;
          if (!cond_c) begin
            we[IDX_A]  = 1'b1;
            nxt[IDX_A] = a_q + b_inv + c_q;
          end
        end else begin
          we[IDX_C]  = 1'b1;
          nxt[IDX_C] = ~c_q;
        end
      end
      default: begin
        we  = '0;
        nxt = cur;
      end
    endcase
  end

  // R7
  no_write_terminal_chk: assert final ((state != ST_S5 && state != ST_IDLE) || we == '0);

endmodule

// File: rtl/fsmd_regfile.sv
module fsmd_regfile #(
  parameter int W = 8,
  parameter int N = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [N-1:0][W-1:0]  init,
  input  logic [N-1:0]         we,
  input  logic [N-1:0][W-1:0]  nxt,
  output logic [N-1:0][W-1:0]  q
);

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= '0;
      else if (load)  q[i] <= init[i];
      else if (we[i]) q[i] <= nxt[i];
    end
  end

  // R1
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(init)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && we == '0) |=> $stable(q));

endmodule

// File: rtl/cond_fsmd.sv
module cond_fsmd
  import fsmd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a_init,
  input  logic [W-1:0] b_init,
  input  logic [W-1:0] c_init,
  input  logic         cond_a,
  input  logic         cond_c,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic [W-1:0] reg_c,
  output logic         done
);

  fsmd_state_t               state;
  logic [NREG-1:0][W-1:0]    init_v, cur, nxt;
  logic [NREG-1:0]           we;

  assign init_v[IDX_A] = a_init;
  assign init_v[IDX_B] = b_init;
  assign init_v[IDX_C] = c_init;

  fsmd_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cond_a (cond_a),
    .cond_c (cond_c),
    .state  (state),
    .done   (done)
  );

  fsmd_alu #(.W(W)) u_alu (
    .state  (state),
    .cond_a (cond_a),
    .cond_c (cond_c),
    .cur    (cur),
    .we     (we),
    .nxt    (nxt)
  );

  fsmd_regfile #(.W(W), .N(NREG)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .load (start),
    .init (init_v),
    .we   (we),
    .nxt  (nxt),
    .q    (cur)
  );

  assign reg_a = cur[IDX_A];
  assign reg_b = cur[IDX_B];
  assign reg_c = cur[IDX_C];

  // R7
  done_state_chk: assert property (@(posedge clk) disable iff (rst)
    done == (state == ST_S5));

  // R7
  terminal_regs_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(reg_a) && $stable(reg_b) && $stable(reg_c)));

  // R2
  s0_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_S0 && !start) |=> (reg_a == W'($past(reg_b) + $past(reg_c))));

endmodule

// File: tb/sim_cond_fsmd.sv
module sim_cond_fsmd;
  localparam int W = 8;
  localparam int M = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst, start, cond_a, cond_c;
  logic [W-1:0] a_init, b_init, c_init, reg_a, reg_b, reg_c;
  logic done;

  always #10 clk = ~clk;

  cond_fsmd #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .a_init(a_init), .b_init(b_init), .c_init(c_init),
    .cond_a(cond_a), .cond_c(cond_c),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int ms = -1;
  int ma = 0, mb = 0, mc = 0;
  int mdone = 0;
  string tag = "R9";
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(int'(reg_a) == ma, tag, "reg_a", int'(reg_a), ma);
    check(int'(reg_b) == mb, tag, "reg_b", int'(reg_b), mb);
    check(int'(reg_c) == mc, tag, "reg_c", int'(reg_c), mc);
    check(int'(done) == mdone, tag, "done", int'(done), mdone);
  endtask

  // One clock: drive at negedge, advance the model, compare at next negedge.
  task automatic cyc(input bit st, input int ai, input int bi, input int ci,
                     input bit xa, input bit xc, input bit restart);
    int nb;
    start = st; a_init = W'(ai); b_init = W'(bi); c_init = W'(ci);
    cond_a = xa; cond_c = xc;
    if (st) begin
      ma = ai & M; mb = bi & M; mc = ci & M; ms = 0;
      tag = restart ? "R10" : "R1";
    end else begin
      case (ms)
        0: begin ma = (mb + mc) & M; ms = 1; tag = "R2"; end
        1: begin
          if (!xa) begin ma = (-ma) & M; ms = 4; end
          else     begin mb = (mb + mc) & M; ms = 2; end
          tag = "R3";
        end
        2: begin
          if (!xc) begin mc = (ma + mb) & M; ms = 5; end
          else     begin mc = (~mc) & M; ms = 3; end
          tag = "R4";
        end
        3: begin
          if (!xc) mc = (ma + mb) & M;
          else     ma = ((~mc) + mb) & M;
          ms = 5; tag = "R5";
        end
        4: begin
          if (!xa) begin
            nb = (~mb) & M;
            if (!xc) ma = (ma + nb + mc) & M;
            mb = nb;
          end else mc = (~mc) & M;
          ms = 5; tag = "R6";
        end
        5: tag = "R7";
        default: tag = "R9";
      endcase
    end
    mdone = (ms == 5);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst = 1'b1; start = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    ms = -1; ma = 0; mb = 0; mc = 0; mdone = 0; tag = "R9";
    compare();
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; cond_a = 1'b0; cond_c = 1'b0;
    a_init = '0; b_init = '0; c_init = '0;
    @(negedge clk);
    do_reset();
    // R9: idle ignores the condition bits
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, k[0], k[1], 0);

    // Every step and every condition pattern, several operand sets
    for (int p = 0; p < 256; p++) begin
      int ai, bi, ci;
      ai = (p * 37 + 11) & M;
      bi = (p * 91 + 200) & M;
      ci = (p * 53 + 7) & M;
      if (p % 16 == 0) begin ai = M; bi = M; ci = M; end
      cyc(1, ai, bi, ci, 0, 0, 0);
      for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, p[2*k], p[2*k+1], 0);
      // R7: terminal step with toggling conditions
      cyc(0, 0, 0, 0, 1, 1, 0);
      cyc(0, 0, 0, 0, 0, 1, 0);
    end

    // R8: wrap of B + C with all-ones operands in step 0
    cyc(1, 3, M, M, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    check(reg_a == W'(M - 1), "R8", "wrap sum", int'(reg_a), M - 1);
    // R8: negation of zero stays zero (B + C = 0 after wrap)
    cyc(1, 0, 1, M, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    check(reg_a == '0, "R8", "negate zero", int'(reg_a), 0);

    // R10: restart mid-run
    cyc(1, 5, 6, 7, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(1, 9, 8, 3, 1, 0, 1);
    check(done == 1'b0 && reg_a == 8'd9, "R10", "restart load", int'(reg_a), 9);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, 0, 0);

    // R9: reset in the middle of a run
    cyc(1, 1, 2, 3, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    do_reset();
    cyc(0, 0, 0, 0, 1, 1, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule